// File: doc/BRIEF.md
# Unlock-Sequence Command Detector

This block watches the read traffic on a static RAM port and looks for a fixed six-read unlock pattern in the address stream. The first five reads must hit five set addresses in a set order. The sixth read selects the command. One ending address asks the memory to copy its contents into the nonvolatile backup. The other ending asks for the backup to be loaded back into the RAM. Any other sixth address is ignored. The block raises a one-clock request pulse for the chosen command and hands it to the transfer engine.

Each bus cycle is presented to the block for one clock, marked by `cyc_valid`. The block uses only the address, the chip-enable, the write flag and that strobe. Output-enable plays no part in recognition. During a sixth read that carries a command ending, the block asserts `dq_hiz` in the same cycle, so that the data pins are released instead of returning RAM data. During the five lead-in reads the RAM answers normally.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset, `store_req`, `recall_req` and `dq_hiz` are low, and the detector is idle, so a complete sequence is needed before any request.
- R2: Six consecutive enabled reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F raise `store_req` high for exactly one clock. The pulse starts on the clock edge that follows the sixth cycle.
- R3: The same five lead-in reads followed by a sixth read at 0x0F0E raise `recall_req` for exactly one clock, with the same timing as R2.
- R4: `dq_hiz` is high, combinationally, only while the presented cycle is a valid, enabled read at the sixth step whose address is 0x0F0F or 0x0F0E. It stays low during the five lead-in reads and during all other cycles.
- R5: A valid, enabled write cycle (`cyc_wr` = 1) at any step returns the detector to idle, whatever its address. The remaining addresses of the pattern then produce no request.
- R6: An enabled read at a lead-in step whose address does not match the expected one returns the detector to idle. If that address is 0x0000, it counts as the first step of a new attempt.
- R7: A cycle with `cyc_en` = 0 or `cyc_valid` = 0 neither advances nor resets the detector.
- R8: After any enabled read at the sixth step, the detector returns to idle. If the address was not one of the two endings, no request is issued.
- R9: `store_req` and `recall_req` are never high together, and neither is high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| cyc_en | input | 1 | Chip enable, active high |
| cyc_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_addr | input | 13 | Cycle address |
| store_req | output | 1 | One-clock request to save RAM to backup |
| recall_req | output | 1 | One-clock request to load backup into RAM |
| dq_hiz | output | 1 | Release the data pins during a command-ending read |

## Verification
The bench targets these corner cases:

- **Write at the sixth step.** A detector that checks only addresses would fire on a write at the final step.
- **Stray 0x0000 mid-sequence.** A design without the restart rule would need an extra 0x0000 and would miss the following command.
- **Disabled or idle cycles between steps.** If these are not ignored, the count either advances on them or is cleared by them.
- **Wrong sixth address, then a valid ending.** A detector that stays armed after the sixth cycle would wrongly issue a command on the next read.
- **Back-to-back store and recall sequences.** These show whether the pulses stretch or overlap.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
  localparam int ADDR_W     = 13;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;
  typedef enum logic [1:0] {CMD_NONE, CMD_STORE, CMD_RECALL} cmd_e;

  // Expected address for a lead-in step (0..PREFIX_LEN-1)
  function automatic addr_t prefix_addr(input step_t idx);
    case (idx)
      step_t'(0): prefix_addr = addr_t'(13'h0000);
      step_t'(1): prefix_addr = addr_t'(13'h1555);
      step_t'(2): prefix_addr = addr_t'(13'h0AAA);
      step_t'(3): prefix_addr = addr_t'(13'h1FFF);
      step_t'(4): prefix_addr = addr_t'(13'h10F0);
      default:    prefix_addr = '0;
    endcase
  endfunction

  // Command selected by the final address
  function automatic cmd_e decode_final(input addr_t a);
    if (a == addr_t'(13'h0F0F))      decode_final = CMD_STORE;
    else if (a == addr_t'(13'h0F0E)) decode_final = CMD_RECALL;
    else                             decode_final = CMD_NONE;
  endfunction
endpackage

// File: rtl/seqcmd_match.sv
module seqcmd_match
  import seqcmd_pkg::*;
(
  input  step_t step,
  input  addr_t addr,
  output logic  step_hit,
  output logic  restart_hit,
  output cmd_e  final_cmd
);
  always_comb begin
    step_hit    = (step < step_t'(PREFIX_LEN)) && (addr == prefix_addr(step));
    restart_hit = (addr == prefix_addr(step_t'(0)));
    final_cmd   = decode_final(addr);
  end
endmodule

// File: rtl/seqcmd_track.sv
module seqcmd_track
  import seqcmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_evt,
  input  logic  wr_evt,
  input  logic  step_hit,
  input  logic  restart_hit,
  output step_t step_q,
  output logic  at_final
);
  step_t step_d;

  assign at_final = (step_q == step_t'(PREFIX_LEN));

  always_comb begin
    step_d = step_q;
    if (wr_evt)                step_d = '0;
    else if (rd_evt) begin
      if (at_final)            step_d = '0;
      else if (step_hit)       step_d = step_q + step_t'(1);
      else if (restart_hit)    step_d = step_t'(1);
      else                     step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  AST_WRITE_ABORT:  assert property (@(posedge clk) disable iff (!rst_n) wr_evt |=> step_q == '0); // R5
  AST_IGNORED_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(rd_evt || wr_evt) |=> $stable(step_q)); // R7
  AST_FINAL_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) (rd_evt && at_final) |=> step_q == '0); // R8
  AST_STEP_RANGE:   assert property (@(posedge clk) disable iff (!rst_n) step_q <= step_t'(PREFIX_LEN)); // R6
endmodule

// File: rtl/seqcmd_pulse.sv
module seqcmd_pulse
  import seqcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  cmd_e cmd,
  output logic store_req,
  output logic recall_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= fire && (cmd == CMD_STORE);
      recall_req <= fire && (cmd == CMD_RECALL);
    end
  end

  AST_REQ_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) !(store_req && recall_req)); // R9
  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) store_req |=> !store_req); // R9
  AST_RECALL_SINGLE:assert property (@(posedge clk) disable iff (!rst_n) recall_req |=> !recall_req); // R9
endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
  import seqcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_valid,
  input  logic              cyc_en,
  input  logic              cyc_wr,
  input  logic [ADDR_W-1:0] cyc_addr,
  output logic              store_req,
  output logic              recall_req,
  output logic              dq_hiz
);
  // Named internal events
  logic  rd_evt, wr_evt;
  logic  step_hit, restart_hit, at_final;
  step_t step;
  cmd_e  final_cmd;

  assign rd_evt = cyc_valid && cyc_en && !cyc_wr;
  assign wr_evt = cyc_valid && cyc_en && cyc_wr;

  seqcmd_match u_match (
    .step        (step),
    .addr        (cyc_addr),
    .step_hit    (step_hit),
    .restart_hit (restart_hit),
    .final_cmd   (final_cmd)
  );

  seqcmd_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_evt      (rd_evt),
    .wr_evt      (wr_evt),
    .step_hit    (step_hit),
    .restart_hit (restart_hit),
    .step_q      (step),
    .at_final    (at_final)
  );

  assign dq_hiz = rd_evt && at_final && (final_cmd != CMD_NONE);

  seqcmd_pulse u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (dq_hiz),
    .cmd        (final_cmd),
    .store_req  (store_req),
    .recall_req (recall_req)
  );

  AST_STORE_CAUSE:  assert property (@(posedge clk) disable iff (!rst_n)
                      store_req |-> ($past(dq_hiz) && $past(cyc_addr) == 13'h0F0F)); // R2
  AST_RECALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
                      recall_req |-> ($past(dq_hiz) && $past(cyc_addr) == 13'h0F0E)); // R3
  AST_HIZ_FINAL:    assert property (@(posedge clk) disable iff (!rst_n)
                      dq_hiz |-> (step == step_t'(PREFIX_LEN) && !cyc_wr)); // R4
endmodule

// File: tb/seqcmd_detect_tb.sv
`timescale 1ns/1ps
module seqcmd_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0, cyc_en = 1'b0, cyc_wr = 1'b0;
  logic [12:0] cyc_addr = '0;
  logic        store_req, recall_req, dq_hiz;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  typedef struct {
    logic  s;
    logic  r;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  seqcmd_detect dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_en(cyc_en),
    .cyc_wr(cyc_wr), .cyc_addr(cyc_addr),
    .store_req(store_req), .recall_req(recall_req), .dq_hiz(dq_hiz)
  );

  // Reference model state
  int m_step = 0;
  logic [12:0] lead [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic en, input logic wr, input logic [12:0] a);
    exp_t e;
    logic eh;
    @(negedge clk);
    cyc_valid = v; cyc_en = en; cyc_wr = wr; cyc_addr = a;
    e.s = 1'b0; e.r = 1'b0; e.tag = cur_req; eh = 1'b0;
    if (v && en) begin
      if (wr) m_step = 0;
      else if (m_step == 5) begin
        if (a == 13'h0F0F) begin e.s = 1'b1; eh = 1'b1; end
        else if (a == 13'h0F0E) begin e.r = 1'b1; eh = 1'b1; end
        m_step = 0;
      end else if (a == lead[m_step]) m_step++;
      else m_step = (a == 13'h0000) ? 1 : 0;
    end
    #1;
    check("R4", dq_hiz, eh, "dq_hiz");
    sb_q.push_back(e);
  endtask

  task automatic rd(input logic [12:0] a);
    cyc(1'b1, 1'b1, 1'b0, a);
  endtask

  task automatic lead_in();
    for (int i = 0; i < 5; i++) rd(lead[i]);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 13'h0000);
  endtask

  // Monitor: compares request outputs with the scoreboard
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, store_req, e.s, "store_req");
      check(e.tag, recall_req, e.r, "recall_req");
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", store_req, 1'b0, "store_req after reset");
    check("R1", recall_req, 1'b0, "recall_req after reset");
    check("R1", dq_hiz, 1'b0, "dq_hiz after reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R1: the ending alone must not fire from idle
    cur_req = "R1"; rd(13'h0F0F); idle(2);
    // R2: store
    cur_req = "R2"; lead_in(); rd(13'h0F0F); idle(2);
    // R3: recall
    cur_req = "R3"; lead_in(); rd(13'h0F0E); idle(2);
    // R7: disabled and non-valid cycles interleaved
    cur_req = "R7";
    rd(13'h0000); cyc(1'b1, 1'b0, 1'b1, 13'h0123); rd(13'h1555);
    cyc(1'b0, 1'b1, 1'b0, 13'h0777); rd(13'h0AAA); cyc(1'b1, 1'b0, 1'b0, 13'h0000);
    rd(13'h1FFF); rd(13'h10F0); cyc(1'b0, 1'b1, 1'b1, 13'h0F0F); rd(13'h0F0F); idle(2);
    // R5: write mid-sequence, then write at the final step
    cur_req = "R5";
    rd(13'h0000); rd(13'h1555); cyc(1'b1, 1'b1, 1'b1, 13'h0AAA);
    rd(13'h0AAA); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F); idle(1);
    lead_in(); cyc(1'b1, 1'b1, 1'b1, 13'h0F0F); rd(13'h0F0F); idle(2);
    // R6: wrong address aborts; stray 0x0000 restarts
    cur_req = "R6";
    rd(13'h0000); rd(13'h1555); rd(13'h0AAB); rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0F); idle(1);
    rd(13'h0000); rd(13'h1555); rd(13'h0000); rd(13'h1555); rd(13'h0AAA);
    rd(13'h1FFF); rd(13'h10F0); rd(13'h0F0E); idle(2);
    // R8: wrong final address, then an ending must not fire
    cur_req = "R8";
    lead_in(); rd(13'h1234); rd(13'h0F0F); idle(1);
    lead_in(); rd(13'h0000); rd(13'h0F0E); idle(2);
    // R9: back-to-back store then recall
    cur_req = "R9";
    lead_in(); rd(13'h0F0F); lead_in(); rd(13'h0F0E); idle(3);
    while (sb_q.size() > 0) @(posedge clk);
    #5;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule